// File: doc/BRIEF.md
# Output Stage Power Sequencer

This block sequences the bias of a multichannel audio output stage so that switching the stage on or off makes no audible click. While the stage is unpowered, held in reset, or has no master clock, it keeps the outputs tied to a bias reference held at its low level. Once the master clock is present, it raises a digital ramp code one step at a time. An external converter turns that code into the bias voltage, and the slow rise lets the output coupling capacitors charge. When the code reaches full scale, the outputs are released to the quiescent level. Audio is then enabled only after an exact number of sample periods with valid serial clocks.

A power-down request lowers the ramp code at a fixed pace and runs a discharge timer of fixed length. The safe-to-remove flag asserts when that timer expires. There is no minimum power-cycle time. Releasing the request at any point, including partway through the discharge, starts a new rise from the present code.

All durations are parameters counted in master-clock cycles or sample ticks, so shortened values can be used for simulation. State encoding is internal. Only the four outputs below are observable.

Top module: `outstage_pwr_seq`

## Requirements
- R1: While `rst_n` is low, or one clock after any edge at which `mclk_ok` is low, the outputs are `clamp_o`=1, `ramp_code`=0, `audio_en`=0 and `safe_off`=0. Master-clock loss overrides every other input.
- R2: From reset release with `mclk_ok`=1 and `pdn_req`=0, the ramp state is entered, and `ramp_code` rises by exactly one every `UP_STEP_CLKS` clocks, counted from entry into that state. The code never falls during the rise.
- R3: One clock after `ramp_code` reaches its all-ones value 2^`CODE_W`-1 in the ramp state, `clamp_o` drops to 0 and the bias-ready state begins with `audio_en`=0.
- R4: In bias-ready, `audio_en` rises one clock after the edge that samples the `AUDIO_WAIT`-th `smp_tick` pulse seen while `frame_ok` and `bclk_ok` are both 1. Any clock with either flag low resets that count to zero.
- R5: While `audio_en`=1, if `frame_ok` or `bclk_ok` is low at an edge, `audio_en` drops at that edge and the block returns to bias-ready with a fresh count.
- R6: At an edge with `pdn_req`=1 and `mclk_ok`=1, any powered state moves to discharge: `clamp_o`=1 and `audio_en`=0. In discharge, `ramp_code` falls by one every `DN_STEP_CLKS` clocks and holds at 0.
- R7: `safe_off` rises after exactly `DN_STEP_CLKS`×(2^`CODE_W`-1) consecutive discharge clocks, whatever code the discharge started from. While `safe_off` is 1, `ramp_code` is 0.
- R8: Deasserting `pdn_req` during discharge or while `safe_off` is 1 clears `safe_off` and restarts the rise from the present `ramp_code` at the next edge.
- R9: `pdn_req` takes priority over the serial clock flags and sample ticks. Entering the powered-up path from the off state with `pdn_req`=1 goes straight to a full-length discharge.
- R10: `audio_en` and `safe_off` are never 1 together, and `audio_en`=1 implies `clamp_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock of the sequencer |
| rst_n | input | 1 | Asynchronous active-low reset |
| mclk_ok | input | 1 | Master clock present |
| frame_ok | input | 1 | Frame (word) clock valid |
| bclk_ok | input | 1 | Bit clock valid |
| smp_tick | input | 1 | One-cycle pulse per audio sample period |
| pdn_req | input | 1 | Power-down request |
| clamp_o | output | 1 | Outputs tied to the bias reference |
| ramp_code | output | CODE_W | Bias ramp code for the external converter |
| audio_en | output | 1 | Audio path enabled |
| safe_off | output | 1 | Supply may be removed |

## Verification
The hardest cases to reach from the ports are a power-down request that is withdrawn partway through discharge, and a sample count that is broken by a clock-flag drop just before it completes. Both depend on where the code and the counters stand at the exact edge of the input change. The bench shortens every duration so that one rise lasts tens of clocks. Directed sequences withdraw the request mid-discharge and drop a serial clock during audio. A long pseudo-random phase then toggles the request, the clock flags, the master clock and reset at low rates, so that these collisions fall at many different counter positions. Every output is compared each cycle with a reference model built from the requirements.

// File: rtl/outstage_pwr_pkg.sv
package outstage_pwr_pkg;
   typedef enum logic [2:0] {
      PS_OFF   = 3'd0,
      PS_RAMP  = 3'd1,
      PS_BIAS  = 3'd2,
      PS_AUDIO = 3'd3,
      PS_DISCH = 3'd4,
      PS_SAFE  = 3'd5
   } pwr_state_e;
endpackage

// File: rtl/opg_pacer.sv
// Free-running divider: strobes once every PERIOD clocks while run is high,
// restarts from zero whenever run is low.
module opg_pacer #(
   parameter int PERIOD = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic strobe
);
   localparam int W = (PERIOD > 1) ? $clog2(PERIOD) : 1;
   localparam logic [W-1:0] LAST = W'(PERIOD - 1);

   generate
      if (PERIOD < 1) begin : g_bad_period
         $error("opg_pacer: PERIOD must be at least 1");
      end
   endgenerate

   logic [W-1:0] cnt_q;

   assign strobe = run && (cnt_q == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt_q <= '0;
      else if (!run)   cnt_q <= '0;
      else if (strobe) cnt_q <= '0;
      else             cnt_q <= cnt_q + W'(1);
   end
endmodule

// File: rtl/opg_code_reg.sv
// Saturating up/down ramp code register.
module opg_code_reg #(
   parameter int CODE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              zero,
   input  logic              inc,
   input  logic              dec,
   output logic [CODE_W-1:0] code,
   output logic              at_max
);
   localparam logic [CODE_W-1:0] TOP = {CODE_W{1'b1}};

   generate
      if (CODE_W < 2 || CODE_W > 16) begin : g_bad_width
         $error("opg_code_reg: CODE_W must lie in 2..16");
      end
   endgenerate

   logic [CODE_W-1:0] code_q;

   assign code   = code_q;
   assign at_max = (code_q == TOP);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       code_q <= '0;
      else if (zero)                    code_q <= '0;
      else if (inc && code_q != TOP)    code_q <= code_q + CODE_W'(1);
      else if (dec && code_q != '0)     code_q <= code_q - CODE_W'(1);
   end
endmodule

// File: rtl/opg_sample_gate.sv
// Counts sample ticks while armed and the serial link is valid; fires on the
// WAIT-th consecutive valid tick. Any invalid clock restarts the count.
module opg_sample_gate #(
   parameter int WAIT = 2000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic arm,
   input  logic link_ok,
   input  logic tick,
   output logic done
);
   localparam int SW = (WAIT > 1) ? $clog2(WAIT) : 1;
   localparam logic [SW-1:0] LAST = SW'(WAIT - 1);

   generate
      if (WAIT < 1) begin : g_bad_wait
         $error("opg_sample_gate: WAIT must be at least 1");
      end
   endgenerate

   logic [SW-1:0] cnt_q;

   assign done = arm && link_ok && tick && (cnt_q == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               cnt_q <= '0;
      else if (!arm || !link_ok) cnt_q <= '0;
      else if (done)            cnt_q <= '0;
      else if (tick)            cnt_q <= cnt_q + SW'(1);
   end
endmodule

// File: rtl/outstage_pwr_seq.sv
module outstage_pwr_seq
   import outstage_pwr_pkg::*;
#(
   parameter int CODE_W       = 8,
   parameter int UP_STEP_CLKS = 4,
   parameter int DN_STEP_CLKS = 4,
   parameter int AUDIO_WAIT   = 2000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mclk_ok,
   input  logic              frame_ok,
   input  logic              bclk_ok,
   input  logic              smp_tick,
   input  logic              pdn_req,
   output logic              clamp_o,
   output logic [CODE_W-1:0] ramp_code,
   output logic              audio_en,
   output logic              safe_off
);
   localparam int CODE_MAX = (1 << CODE_W) - 1;
   localparam int DIS_CLKS = DN_STEP_CLKS * CODE_MAX;

   generate
      if (UP_STEP_CLKS < 1 || DN_STEP_CLKS < 1) begin : g_bad_step
         $error("outstage_pwr_seq: step periods must be at least 1");
      end
      if (AUDIO_WAIT < 1) begin : g_bad_wait
         $error("outstage_pwr_seq: AUDIO_WAIT must be at least 1");
      end
   endgenerate

   pwr_state_e st_q, st_d;
   logic       link_ok;
   logic       up_stb, dn_stb, dis_done, gate_done, at_max;
   logic       code_inc, code_dec;

   assign link_ok = frame_ok & bclk_ok;

   opg_pacer #(.PERIOD(UP_STEP_CLKS)) u_up_pace (
      .clk(clk), .rst_n(rst_n), .run(st_q == PS_RAMP), .strobe(up_stb)
   );

   opg_pacer #(.PERIOD(DN_STEP_CLKS)) u_dn_pace (
      .clk(clk), .rst_n(rst_n), .run(st_q == PS_DISCH), .strobe(dn_stb)
   );

   opg_pacer #(.PERIOD(DIS_CLKS)) u_dis_timer (
      .clk(clk), .rst_n(rst_n), .run(st_q == PS_DISCH), .strobe(dis_done)
   );

   assign code_inc = (st_q == PS_RAMP)  && mclk_ok && !pdn_req && up_stb;
   assign code_dec = (st_q == PS_DISCH) && mclk_ok &&  pdn_req && dn_stb;

   opg_code_reg #(.CODE_W(CODE_W)) u_code (
      .clk(clk), .rst_n(rst_n), .zero(!mclk_ok),
      .inc(code_inc), .dec(code_dec), .code(ramp_code), .at_max(at_max)
   );

   opg_sample_gate #(.WAIT(AUDIO_WAIT)) u_gate (
      .clk(clk), .rst_n(rst_n), .arm(st_q == PS_BIAS),
      .link_ok(link_ok), .tick(smp_tick), .done(gate_done)
   );

   always_comb begin
      st_d = st_q;
      if (!mclk_ok) begin
         st_d = PS_OFF;
      end else begin
         unique case (st_q)
            PS_OFF:   st_d = pdn_req ? PS_DISCH : PS_RAMP;
            PS_RAMP:  if (pdn_req)        st_d = PS_DISCH;
                      else if (at_max)    st_d = PS_BIAS;
            PS_BIAS:  if (pdn_req)        st_d = PS_DISCH;
                      else if (gate_done) st_d = PS_AUDIO;
            PS_AUDIO: if (pdn_req)        st_d = PS_DISCH;
                      else if (!link_ok)  st_d = PS_BIAS;
            PS_DISCH: if (!pdn_req)       st_d = PS_RAMP;
                      else if (dis_done)  st_d = PS_SAFE;
            PS_SAFE:  if (!pdn_req)       st_d = PS_RAMP;
            default:  st_d = PS_OFF;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= PS_OFF;
      else        st_q <= st_d;
   end

   assign clamp_o  = !((st_q == PS_BIAS) || (st_q == PS_AUDIO));
   assign audio_en = (st_q == PS_AUDIO);
   assign safe_off = (st_q == PS_SAFE);
endmodule

// File: rtl/opg_checker.sv
module opg_checker
   import outstage_pwr_pkg::*;
#(
   parameter int CODE_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              mclk_ok,
   input logic              pdn_req,
   input logic              clamp_o,
   input logic [CODE_W-1:0] ramp_code,
   input logic              audio_en,
   input logic              safe_off,
   input pwr_state_e        st
);
   a_r1_mclk_loss: assert property (@(posedge clk) disable iff (!rst_n)
      !mclk_ok |=> (clamp_o && ramp_code == '0 && !audio_en && !safe_off));

   a_r2_rise_step: assert property (@(posedge clk) disable iff (!rst_n)
      (st == PS_RAMP && mclk_ok && !pdn_req) |=>
         (ramp_code == $past(ramp_code) || ramp_code == $past(ramp_code) + CODE_W'(1)));

   a_r6_pdn_mutes: assert property (@(posedge clk) disable iff (!rst_n)
      (mclk_ok && pdn_req) |=> (clamp_o && !audio_en));

   a_r6_disch_falls: assert property (@(posedge clk) disable iff (!rst_n)
      (st == PS_DISCH && mclk_ok && pdn_req) |=> (ramp_code <= $past(ramp_code)));

   a_r7_safe_zero: assert property (@(posedge clk) disable iff (!rst_n)
      safe_off |-> (ramp_code == '0 && clamp_o));

   a_r8_release: assert property (@(posedge clk) disable iff (!rst_n)
      (safe_off && mclk_ok && !pdn_req) |=> !safe_off);

   a_r10_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(safe_off && audio_en));

   a_r10_unclamped: assert property (@(posedge clk) disable iff (!rst_n)
      audio_en |-> !clamp_o);
endmodule

bind outstage_pwr_seq opg_checker #(.CODE_W(CODE_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .mclk_ok(mclk_ok), .pdn_req(pdn_req),
   .clamp_o(clamp_o), .ramp_code(ramp_code), .audio_en(audio_en),
   .safe_off(safe_off), .st(st_q)
);

// File: tb/outstage_pwr_seq_tb.sv
module outstage_pwr_seq_tb;
   localparam int CW   = 4;
   localparam int UPS  = 3;
   localparam int DNS  = 2;
   localparam int WT   = 6;
   localparam int CMAX = (1 << CW) - 1;
   localparam int TOT  = DNS * CMAX;

   localparam int M_OFF = 0, M_RAMP = 1, M_BIAS = 2, M_AUDIO = 3, M_DISCH = 4, M_SAFE = 5;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          mclk_ok = 1'b0, frame_ok = 1'b0, bclk_ok = 1'b0;
   logic          smp_tick = 1'b0, pdn_req = 1'b0;
   logic          clamp_o, audio_en, safe_off;
   logic [CW-1:0] ramp_code;

   int n_vec = 0, n_bad = 0;
   int tick_per = 0, tick_ctr = 0;

   // reference model state
   int m_st = M_OFF, m_code = 0, m_up = 0, m_dn = 0, m_dis = 0, m_smp = 0;

   always #10 clk = ~clk;

   outstage_pwr_seq #(
      .CODE_W(CW), .UP_STEP_CLKS(UPS), .DN_STEP_CLKS(DNS), .AUDIO_WAIT(WT)
   ) u_dut (
      .clk(clk), .rst_n(rst_n), .mclk_ok(mclk_ok), .frame_ok(frame_ok),
      .bclk_ok(bclk_ok), .smp_tick(smp_tick), .pdn_req(pdn_req),
      .clamp_o(clamp_o), .ramp_code(ramp_code), .audio_en(audio_en),
      .safe_off(safe_off)
   );

   function automatic bit exp_clamp(int s);
      return !(s == M_BIAS || s == M_AUDIO);
   endfunction

   // Cycle model built from R1..R10
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n || !mclk_ok) begin
         m_st = M_OFF; m_code = 0; m_up = 0; m_dn = 0; m_dis = 0; m_smp = 0;
      end else begin
         case (m_st)
            M_OFF:   m_st = pdn_req ? M_DISCH : M_RAMP;
            M_RAMP: begin
               if (pdn_req)              m_st = M_DISCH;
               else if (m_code == CMAX)  m_st = M_BIAS;
               else if (m_up == UPS - 1) begin m_up = 0; m_code++; end
               else                      m_up++;
            end
            M_BIAS: begin
               if (pdn_req)                   m_st = M_DISCH;
               else if (!(frame_ok && bclk_ok)) m_smp = 0;
               else if (smp_tick) begin
                  if (m_smp == WT - 1) begin m_st = M_AUDIO; m_smp = 0; end
                  else m_smp++;
               end
            end
            M_AUDIO: begin
               if (pdn_req)                     m_st = M_DISCH;
               else if (!(frame_ok && bclk_ok)) m_st = M_BIAS;
            end
            M_DISCH: begin
               if (!pdn_req) m_st = M_RAMP;
               else begin
                  if (m_dn == DNS - 1) begin
                     m_dn = 0;
                     if (m_code > 0) m_code--;
                  end else m_dn++;
                  if (m_dis == TOT - 1) begin m_dis = 0; m_st = M_SAFE; end
                  else m_dis++;
               end
            end
            default: if (!pdn_req) m_st = M_RAMP;
         endcase
         if (m_st != M_RAMP)  m_up = 0;
         if (m_st != M_DISCH) begin m_dn = 0; m_dis = 0; end
         if (m_st != M_BIAS)  m_smp = 0;
      end
   end

   task automatic check();
      n_vec++;
      if (clamp_o !== exp_clamp(m_st)) begin
         n_bad++;
         $display("FAIL R1 R3 R6 clamp_o: actual=%0b expected=%0b t=%0t", clamp_o, exp_clamp(m_st), $time);
      end
      if (ramp_code !== CW'(m_code)) begin
         n_bad++;
         $display("FAIL R2 R6 R8 ramp_code: actual=%0d expected=%0d t=%0t", ramp_code, m_code, $time);
      end
      if (audio_en !== (m_st == M_AUDIO)) begin
         n_bad++;
         $display("FAIL R4 R5 R9 audio_en: actual=%0b expected=%0b t=%0t", audio_en, m_st == M_AUDIO, $time);
      end
      if (safe_off !== (m_st == M_SAFE)) begin
         n_bad++;
         $display("FAIL R7 R8 safe_off: actual=%0b expected=%0b t=%0t", safe_off, m_st == M_SAFE, $time);
      end
      if (safe_off === 1'b1 && audio_en === 1'b1) begin
         n_bad++;
         $display("FAIL R10 exclusive: actual=both expected=one t=%0t", $time);
      end
   endtask

   task automatic cyc(int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         check();
         tick_ctr++;
         smp_tick = (tick_per != 0) && (tick_ctr % tick_per == 0);
      end
   endtask

   task automatic rnd(int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         check();
         rst_n    = ($urandom % 1000) != 0;
         mclk_ok  = ($urandom % 100) < 98;
         if (($urandom % 100) < 2) pdn_req = ~pdn_req;
         frame_ok = ($urandom % 100) < 96;
         bclk_ok  = ($urandom % 100) < 97;
         smp_tick = ($urandom % 4) == 0;
      end
   endtask

   task automatic finish_run();
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   endtask

   initial begin
      #(20 * 150000);
      n_bad++;
      $display("FAIL R1 watchdog: actual=hung expected=finished");
      finish_run();
   end

   initial begin
      void'($urandom(32'd4242));
      // R1: reset state, then no master clock keeps everything clamped
      cyc(3);
      rst_n = 1'b1;
      cyc(5);
      // R2 R3 R4: full rise then exact sample-count gating
      mclk_ok = 1'b1; frame_ok = 1'b1; bclk_ok = 1'b1; tick_per = 4;
      cyc(100);
      // R5: frame clock drop while audio is on, then recovery
      frame_ok = 1'b0; cyc(8);
      frame_ok = 1'b1; cyc(20);
      bclk_ok = 1'b0;  cyc(1);
      bclk_ok = 1'b1;  cyc(40);
      // R6 R7: full discharge to safe
      pdn_req = 1'b1; cyc(40);
      // R8: release from safe, rise again
      pdn_req = 1'b0; cyc(80);
      // R8: release partway through discharge
      pdn_req = 1'b1; cyc(11);
      pdn_req = 1'b0; cyc(70);
      // R9: request wins over clock flags; master clock loss wins over all
      pdn_req = 1'b1; frame_ok = 1'b0; cyc(5);
      mclk_ok = 1'b0; cyc(3);
      mclk_ok = 1'b1; cyc(40);
      pdn_req = 1'b0; frame_ok = 1'b1; cyc(100);
      // mixed pseudo-random phase covering R1..R10 collisions
      tick_per = 0;
      rnd(30000);
      finish_run();
   end
endmodule